// File: doc/BRIEF.md
# PHY Interrupt and Link-Wake Register Block

This block is the control and status register slice of a serial-bus physical layer. It stores a link-active control bit, the contender bit, a three-bit power class, a watchdog enable and a request for a short bus reset. It also holds four sticky interrupt flags: configuration timeout, cable power drop, state timeout and port event. From these it drives the link, contender and power fields of the self-ID packet. The arbitration, tree-ID and self-ID machines are outside this block and deliver their events as one-cycle pulses.

Two reset sources act on the block. Hardware reset (`hw_rst`) brings every field to its initial state. Bus reset (`bus_rst`) only withdraws the short bus reset request. Software reads and writes the block through a plain address/data bus. The interrupt flags are cleared by writing 1 to them. When the watchdog enable is set, a pending timeout or cable-power flag raises the `link_on` wake output for as long as the link layer reports itself inactive.

Top module: `phy_irq_wake`

## Requirements
- R1: `selfid_link` equals the link-control bit (CTRL bit 0) AND `lps`; it is 0 whenever `lps` is 0.
- R2: Hardware reset sets link-control to 1 and contender (CTRL bit 1) to 0. Only a CTRL write changes either bit; bus reset leaves both unchanged.
- R3: Hardware reset loads the power class (CTRL bits 6:4, driven on `selfid_pwr`) from `pc_strap`. Bus reset leaves it unchanged, and a CTRL write replaces it.
- R4: The short bus reset request (CTRL bit 3, output `short_rst_req`) is written by software and cleared by bus reset. If a bus reset and a write fall in the same cycle, the bus reset wins.
- R5: `cps` passes through a two-stage synchronizer. A high-to-low transition on `cps` sets the cable-power flag (IRQ bit 1) at the third rising edge after the change. Hardware reset sets this flag to 1.
- R6: The IRQ register at address 1 holds configuration timeout (bit 0, set by `cfg_timeout_evt`), cable power (bit 1), state timeout (bit 2, set by `state_timeout_evt`) and port event (bit 3). Writing 1 to a bit clears it, and writing 0 has no effect. Hardware reset clears bits 0, 2 and 3.
- R7: An event that arrives in the same cycle as a write-1-to-clear of its flag leaves the flag set.
- R8: The port event flag sets one edge after the 4-bit status of a port changes, if that port's enable bit is set in PIE (address 2, bit p for port p). When the watchdog enable (CTRL bit 2) is set, the flag also sets on any `port_resume` pulse.
- R9: `link_on` is 1 exactly when the watchdog enable is 1, at least one of IRQ bits 0, 1 or 2 is set, and `lps` is 0.
- R10: `link_if_en` follows `lps` whatever the link-control bit holds.
- R11: Reads return CTRL at address 0, IRQ at address 1 and PIE at address 2, each zero-extended. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst | input | 1 | Synchronous hardware reset, active high |
| bus_rst | input | 1 | Bus reset pulse |
| pc_strap | input | 3 | Power class configuration pins |
| lps | input | 1 | Link power status, 1 = link active |
| cps | input | 1 | Cable power status, asynchronous |
| cfg_timeout_evt | input | 1 | Configuration timeout event pulse |
| state_timeout_evt | input | 1 | State timeout event pulse |
| port_stat | input | NPORTS*4 | Per-port connected/bias/disabled/fault status |
| port_resume | input | NPORTS | Per-port resume start pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| selfid_link | output | 1 | Self-ID link-active field |
| selfid_contender | output | 1 | Self-ID contender field |
| selfid_pwr | output | 3 | Self-ID power class field |
| short_rst_req | output | 1 | Pending short bus reset request |
| link_on | output | 1 | Link wake request |
| link_if_en | output | 1 | Link interface running |

## Verification
Two pairs of actions can land in the same cycle. A flag event can coincide with a write-1-to-clear of that flag, and a bus reset can coincide with a software write that sets the short reset request. The bench provokes both on purpose. It drives `cfg_timeout_evt` in the same cycle as a clearing write to IRQ, and it raises `bus_rst` in the same cycle as a CTRL write with bit 3 set. On the next cycle it expects the flag to be set and the request to be clear. A behavioural model, updated at each rising edge, is compared with every output on every falling edge, so any wrong choice of winner is reported in the cycle it appears.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;

    localparam int DATA_W      = 8;
    localparam int PORT_STAT_W = 4;
    localparam int SYNC_STAGES = 2;

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_IRQ  = 1;
    localparam int ADDR_PIE  = 2;

    typedef struct packed {
        logic       rsvd;
        logic [2:0] pwr;
        logic       short_rst;
        logic       wdog_en;
        logic       contender;
        logic       link_ctrl;
    } ctrl_t;

    typedef struct packed {
        logic [3:0] rsvd;
        logic       port_evt;
        logic       state_to;
        logic       cable_pwr;
        logic       cfg_to;
    } irq_t;

    localparam irq_t IRQ_RST_VAL  = '{rsvd: 4'h0, port_evt: 1'b0, state_to: 1'b0,
                                      cable_pwr: 1'b1, cfg_to: 1'b0};
    localparam irq_t IRQ_LIVE_MSK = '{rsvd: 4'h0, port_evt: 1'b1, state_to: 1'b1,
                                      cable_pwr: 1'b1, cfg_to: 1'b1};

    function automatic ctrl_t ctrl_from_byte(input logic [DATA_W-1:0] b);
        ctrl_t c;
        c      = ctrl_t'(b);
        c.rsvd = 1'b0;
        return c;
    endfunction

    function automatic logic wake_cause(input irq_t f);
        return f.cfg_to | f.cable_pwr | f.state_to;
    endfunction

endpackage

// File: rtl/piw_cps_sync.sv
module piw_cps_sync
    import phy_irq_pkg::*;
(
    input  logic clk,
    input  logic hw_rst,
    input  logic cps_in,
    output logic cps_fall
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (hw_rst) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], cps_in};
        end
    end

    // Last synchronized sample low while the one before it was high.
    assign cps_fall = chain_q[CHAIN_W-1] & ~chain_q[CHAIN_W-2];

endmodule

// File: rtl/piw_ctrl_regs.sv
module piw_ctrl_regs
    import phy_irq_pkg::*;
#(
    parameter int NPORTS = 3
) (
    input  logic              clk,
    input  logic              hw_rst,
    input  logic              bus_rst,
    input  logic [2:0]        pc_strap,
    input  logic              wr_ctrl,
    input  logic              wr_pie,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl_q,
    output logic [NPORTS-1:0] pie_q
);
    always_ff @(posedge clk) begin
        if (hw_rst) begin
            ctrl_q <= '{rsvd: 1'b0, pwr: pc_strap, short_rst: 1'b0,
                        wdog_en: 1'b0, contender: 1'b0, link_ctrl: 1'b1};
            pie_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= ctrl_from_byte(wdata);
            end
            // Bus reset overrides a same-cycle request write.
            if (bus_rst) begin
                ctrl_q.short_rst <= 1'b0;
            end
            if (wr_pie) begin
                pie_q <= wdata[NPORTS-1:0];
            end
        end
    end

endmodule

// File: rtl/piw_port_detect.sv
module piw_port_detect
    import phy_irq_pkg::*;
#(
    parameter int NPORTS = 3
) (
    input  logic                          clk,
    input  logic [NPORTS*PORT_STAT_W-1:0] port_stat,
    input  logic [NPORTS-1:0]             port_resume,
    input  logic [NPORTS-1:0]             pie,
    input  logic                          wdog_en,
    output logic                          port_evt
);
    localparam int STAT_W = NPORTS * PORT_STAT_W;

    logic [STAT_W-1:0] prev_q;
    logic [NPORTS-1:0] hit;

    always_ff @(posedge clk) begin
        prev_q <= port_stat;
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        assign hit[p] = pie[p] &&
            (port_stat[p*PORT_STAT_W +: PORT_STAT_W] != prev_q[p*PORT_STAT_W +: PORT_STAT_W]);
    end

    assign port_evt = (|hit) | (wdog_en & (|port_resume));

endmodule

// File: rtl/piw_irq_flags.sv
module piw_irq_flags
    import phy_irq_pkg::*;
(
    input  logic clk,
    input  logic hw_rst,
    input  irq_t set_i,
    input  irq_t clr_i,
    output irq_t flags_q
);
    always_ff @(posedge clk) begin
        if (hw_rst) begin
            flags_q <= IRQ_RST_VAL;
        end else begin
            // Set term is ORed last so a same-cycle event beats the clear.
            flags_q <= irq_t'(((flags_q & ~clr_i) | set_i) & IRQ_LIVE_MSK);
        end
    end

endmodule

// File: rtl/phy_irq_wake.sv
module phy_irq_wake
    import phy_irq_pkg::*;
#(
    parameter int NPORTS = 3,
    parameter int ADDR_W = 2
) (
    input  logic                          clk,
    input  logic                          hw_rst,
    input  logic                          bus_rst,
    input  logic [2:0]                    pc_strap,
    input  logic                          lps,
    input  logic                          cps,
    input  logic                          cfg_timeout_evt,
    input  logic                          state_timeout_evt,
    input  logic [NPORTS*PORT_STAT_W-1:0] port_stat,
    input  logic [NPORTS-1:0]             port_resume,
    input  logic                          reg_wr,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [DATA_W-1:0]             reg_wdata,
    output logic [DATA_W-1:0]             reg_rdata,
    output logic                          selfid_link,
    output logic                          selfid_contender,
    output logic [2:0]                    selfid_pwr,
    output logic                          short_rst_req,
    output logic                          link_on,
    output logic                          link_if_en
);
    ctrl_t             ctrl_q;
    irq_t              irq_q;
    irq_t              irq_set;
    irq_t              irq_clr;
    logic [NPORTS-1:0] pie_q;
    logic              wr_ctrl, wr_irq, wr_pie;
    logic              cps_fall;
    logic              port_evt;

    assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(ADDR_CTRL));
    assign wr_irq  = reg_wr && (reg_addr == ADDR_W'(ADDR_IRQ));
    assign wr_pie  = reg_wr && (reg_addr == ADDR_W'(ADDR_PIE));

    piw_ctrl_regs #(.NPORTS(NPORTS)) u_ctrl (
        .clk     (clk),
        .hw_rst  (hw_rst),
        .bus_rst (bus_rst),
        .pc_strap(pc_strap),
        .wr_ctrl (wr_ctrl),
        .wr_pie  (wr_pie),
        .wdata   (reg_wdata),
        .ctrl_q  (ctrl_q),
        .pie_q   (pie_q)
    );

    piw_cps_sync u_cps (
        .clk     (clk),
        .hw_rst  (hw_rst),
        .cps_in  (cps),
        .cps_fall(cps_fall)
    );

    piw_port_detect #(.NPORTS(NPORTS)) u_port (
        .clk        (clk),
        .port_stat  (port_stat),
        .port_resume(port_resume),
        .pie        (pie_q),
        .wdog_en    (ctrl_q.wdog_en),
        .port_evt   (port_evt)
    );

    always_comb begin
        irq_set           = '0;
        irq_set.cfg_to    = cfg_timeout_evt;
        irq_set.cable_pwr = cps_fall;
        irq_set.state_to  = state_timeout_evt;
        irq_set.port_evt  = port_evt;
        irq_clr           = wr_irq ? irq_t'(reg_wdata) : '0;
    end

    piw_irq_flags u_flags (
        .clk    (clk),
        .hw_rst (hw_rst),
        .set_i  (irq_set),
        .clr_i  (irq_clr),
        .flags_q(irq_q)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(ADDR_CTRL): reg_rdata = ctrl_q;
            ADDR_W'(ADDR_IRQ):  reg_rdata = irq_q;
            ADDR_W'(ADDR_PIE):  reg_rdata[NPORTS-1:0] = pie_q;
            default:            reg_rdata = '0;
        endcase
    end

    assign selfid_link      = ctrl_q.link_ctrl & lps;
    assign selfid_contender = ctrl_q.contender;
    assign selfid_pwr       = ctrl_q.pwr;
    assign short_rst_req    = ctrl_q.short_rst;
    assign link_on          = ctrl_q.wdog_en & wake_cause(irq_q) & ~lps;
    assign link_if_en       = lps;

endmodule

// File: rtl/piw_checker.sv
module piw_checker
    import phy_irq_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              hw_rst,
    input logic              bus_rst,
    input logic              lps,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              cfg_timeout_evt,
    input logic              selfid_link,
    input logic              selfid_contender,
    input logic              short_rst_req,
    input logic              link_on,
    input irq_t              irq_q,
    input ctrl_t             ctrl_q
);
    assert_lps_gate_R1: assert property (@(posedge clk) disable iff (hw_rst)
        !lps |-> !selfid_link);

    assert_busrst_keeps_contender_R2: assert property (@(posedge clk) disable iff (hw_rst)
        (bus_rst && !reg_wr) |=> $stable(selfid_contender));

    assert_busrst_clears_req_R4: assert property (@(posedge clk) disable iff (hw_rst)
        bus_rst |=> !short_rst_req);

    assert_clear_needs_write_R6: assert property (@(posedge clk) disable iff (hw_rst)
        !(reg_wr && reg_addr == ADDR_W'(ADDR_IRQ)) |=> !$fell(irq_q.cfg_to));

    assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (hw_rst)
        cfg_timeout_evt |=> irq_q.cfg_to);

    assert_wake_needs_idle_R9: assert property (@(posedge clk) disable iff (hw_rst)
        link_on |-> (!lps && ctrl_q.wdog_en));

    assert_wake_pending_R9: assert property (@(posedge clk) disable iff (hw_rst)
        (ctrl_q.wdog_en && !lps && irq_q.cable_pwr) |-> link_on);

endmodule

bind phy_irq_wake piw_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .hw_rst          (hw_rst),
    .bus_rst         (bus_rst),
    .lps             (lps),
    .reg_wr          (reg_wr),
    .reg_addr        (reg_addr),
    .cfg_timeout_evt (cfg_timeout_evt),
    .selfid_link     (selfid_link),
    .selfid_contender(selfid_contender),
    .short_rst_req   (short_rst_req),
    .link_on         (link_on),
    .irq_q           (irq_q),
    .ctrl_q          (ctrl_q)
);

// File: tb/tb_phy_irq_wake.sv
module tb_phy_irq_wake;
    localparam int NP = 3;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          hw_rst = 1'b1, bus_rst = 1'b0;
    logic [2:0]    pc_strap = 3'b101;
    logic          lps = 1'b1, cps = 1'b1;
    logic          cfg_timeout_evt = 1'b0, state_timeout_evt = 1'b0;
    logic [NP*4-1:0] port_stat = '0;
    logic [NP-1:0] port_resume = '0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          selfid_link, selfid_contender, short_rst_req, link_on, link_if_en;
    logic [2:0]    selfid_pwr;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    phy_irq_wake #(.NPORTS(NP), .ADDR_W(AW)) dut (.*);

    // ---------------- behavioural reference model ----------------
    bit       mvalid = 1'b0;
    bit       m_link, m_cont, m_wdog, m_srst;
    bit [2:0] m_pwr;
    bit       m_cfg, m_cpsf, m_st, m_pe;
    bit [NP-1:0]   m_ie;
    bit [NP*4-1:0] m_prev;
    bit       cps_hist[$];

    always @(posedge clk) begin
        bit fall, pe_set, clr_sel;
        if (hw_rst) begin
            m_link = 1; m_cont = 0; m_wdog = 0; m_srst = 0; m_pwr = pc_strap;
            m_cfg = 0; m_cpsf = 1; m_st = 0; m_pe = 0; m_ie = '0;
            cps_hist = '{1'b1, 1'b1, 1'b1};
            mvalid = 1'b1;
        end else begin
            fall = cps_hist[2] && !cps_hist[1];
            pe_set = m_wdog && (port_resume != 0);
            for (int p = 0; p < NP; p++)
                if (m_ie[p] && port_stat[p*4 +: 4] != m_prev[p*4 +: 4]) pe_set = 1;
            clr_sel = reg_wr && reg_addr == 2'd1;
            m_cfg  = (m_cfg  && !(clr_sel && reg_wdata[0])) || cfg_timeout_evt;
            m_cpsf = (m_cpsf && !(clr_sel && reg_wdata[1])) || fall;
            m_st   = (m_st   && !(clr_sel && reg_wdata[2])) || state_timeout_evt;
            m_pe   = (m_pe   && !(clr_sel && reg_wdata[3])) || pe_set;
            if (reg_wr && reg_addr == 2'd0) begin
                m_link = reg_wdata[0]; m_cont = reg_wdata[1]; m_wdog = reg_wdata[2];
                m_srst = reg_wdata[3]; m_pwr = reg_wdata[6:4];
            end
            if (bus_rst) m_srst = 0;
            if (reg_wr && reg_addr == 2'd2) m_ie = reg_wdata[NP-1:0];
            cps_hist.push_front(cps);
            while (cps_hist.size() > 3) void'(cps_hist.pop_back());
        end
        m_prev = port_stat;
    end

    task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        logic [7:0] exp_rd;
        if (mvalid && !hw_rst && !done) begin
            case (reg_addr)
                2'd0: exp_rd = {1'b0, m_pwr, m_srst, m_wdog, m_cont, m_link};
                2'd1: exp_rd = {4'b0, m_pe, m_st, m_cpsf, m_cfg};
                2'd2: exp_rd = 8'(m_ie);
                default: exp_rd = 8'h00;
            endcase
            cmp("R1 selfid_link", 8'(selfid_link), 8'(m_link && lps));
            cmp("R2 selfid_contender", 8'(selfid_contender), 8'(m_cont));
            cmp("R3 selfid_pwr", 8'(selfid_pwr), 8'(m_pwr));
            cmp("R4 short_rst_req", 8'(short_rst_req), 8'(m_srst));
            cmp("R9 link_on", 8'(link_on), 8'(m_wdog && (m_cfg || m_cpsf || m_st) && !lps));
            cmp("R10 link_if_en", 8'(link_if_en), 8'(lps));
            cmp("R11 R5 R6 R7 R8 reg_rdata", reg_rdata, exp_rd);
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(input int n = 1);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d; tick(); reg_wr = 0;
    endtask

    initial begin
        tick(3);
        hw_rst = 0;
        reg_addr = 2'd0; tick();
        cmp("R2 R3 CTRL after hw reset", reg_rdata, 8'h51);
        reg_addr = 2'd1; tick();
        cmp("R5 IRQ after hw reset", reg_rdata, 8'h02);

        lps = 0; tick();
        cmp("R1 link gated by lps", 8'(selfid_link), 8'h00);
        cmp("R10 interface follows lps", 8'(link_if_en), 8'h00);
        lps = 1;
        wr(2'd0, 8'h50); tick();
        cmp("R1 link ctrl cleared", 8'(selfid_link), 8'h00);
        cmp("R10 interface runs with ctrl 0", 8'(link_if_en), 8'h01);

        wr(2'd0, 8'h5B); tick();
        bus_rst = 1; tick(); bus_rst = 0; tick();
        cmp("R2 contender kept over bus reset", 8'(selfid_contender), 8'h01);
        cmp("R4 bus reset clears request", 8'(short_rst_req), 8'h00);
        cmp("R3 pwr kept over bus reset", 8'(selfid_pwr), 8'h05);

        bus_rst = 1; wr(2'd0, 8'h5B); bus_rst = 0; tick();
        cmp("R4 bus reset beats write", 8'(short_rst_req), 8'h00);

        wr(2'd0, 8'h21); tick();
        cmp("R3 pwr written", 8'(selfid_pwr), 8'h02);

        reg_addr = 2'd1;
        wr(2'd1, 8'h00); tick();
        cmp("R6 write 0 keeps flag", reg_rdata, 8'h02);
        wr(2'd1, 8'h02); tick();
        cmp("R6 write 1 clears flag", reg_rdata, 8'h00);

        cps = 0; tick(2);
        cmp("R5 not yet after two edges", reg_rdata, 8'h00);
        tick();
        cmp("R5 cable flag on third edge", reg_rdata, 8'h02);
        cps = 1; wr(2'd1, 8'h02); tick();

        cfg_timeout_evt = 1; wr(2'd1, 8'h01); cfg_timeout_evt = 0;
        cmp("R7 set beats clear", reg_rdata, 8'h01);
        wr(2'd1, 8'h01); tick();

        wr(2'd0, 8'h25); lps = 0;
        state_timeout_evt = 1; tick(); state_timeout_evt = 0; tick();
        cmp("R9 wake with link idle", 8'(link_on), 8'h01);
        lps = 1; tick();
        cmp("R9 no wake with link active", 8'(link_on), 8'h00);
        lps = 0; wr(2'd1, 8'h04); tick();
        cmp("R9 wake drops after clear", 8'(link_on), 8'h00);

        reg_addr = 2'd1;
        port_stat[1:0] = 2'b11; tick(2);
        cmp("R8 disabled port ignored", reg_rdata, 8'h00);
        wr(2'd2, 8'h02); reg_addr = 2'd1;
        port_stat[2] = 1; tick(2);
        cmp("R8 port 0 still ignored", reg_rdata, 8'h00);
        port_stat[7] = 1; tick();
        cmp("R8 port 1 change sets flag", reg_rdata, 8'h08);
        wr(2'd1, 8'h08); tick();
        port_resume = 3'b100; tick(); port_resume = 0;
        cmp("R8 resume with watchdog", reg_rdata, 8'h08);
        wr(2'd1, 8'h08); wr(2'd0, 8'h21); reg_addr = 2'd1;
        port_resume = 3'b001; tick(); port_resume = 0; tick();
        cmp("R8 resume ignored without watchdog", reg_rdata, 8'h00);

        reg_addr = 2'd3; tick();
        cmp("R11 unused address reads zero", reg_rdata, 8'h00);
        reg_addr = 2'd2; tick();
        cmp("R11 PIE readback", reg_rdata, 8'h02);

        pc_strap = 3'b011; hw_rst = 1; tick(2); hw_rst = 0; reg_addr = 2'd0; tick();
        cmp("R2 R3 second hw reset", reg_rdata, 8'h31);
        tick(4);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual %0d expected below 5000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule